// File: doc/BRIEF.md
# Low-Voltage Status Filter

This block qualifies two raw supply-monitor comparator results and turns them into one stable low-voltage flag. The first input is high while the supply is under the falling trip level. The second input is high while the supply is over the rising trip level. When neither input is high, the supply is inside the hysteresis band. Both inputs are asynchronous to the reference clock, so each passes through a two-flop synchronizer before any logic uses it. After that, a qualification counter requires the under-voltage condition to last before the flag is set.

The flag clears as soon as the synchronized supply is seen above the rising trip level. It keeps its value while the supply is inside the band. Software reads the flag as bit 7 of a read-only status byte on a simple CPU bus.

Two configuration bits control the block. A power-enable bit keeps the monitor running during wait mode. A reset-enable bit lets a qualified low-voltage condition raise a reset request, which also ends wait mode. The block has an interrupt output, and that output is always low.

Top module: `lvd_status_filter`

## Requirements
- R1: Both comparator inputs are synchronized through two reference-clock flops. The counter then needs 36 consecutive synchronized low samples, which lands inside the 32-to-40-cycle qualification window. The flag therefore reads 1 exactly 38 reference-clock edges after `below_fall_i` rises, and 0 after 37 edges.
- R2: If the supply has stayed low for fewer than the qualification cycles, the flag reads 0. A sample without the low condition restarts the count from zero.
- R3: The flag stays 1 for as long as the low condition lasts past the window.
- R4: Once `above_rise_i` is high and the monitor is active, the flag reads 0 within three reference-clock edges.
- R5: When neither comparator input is high, the flag keeps its previous value.
- R6: A read (`bus_sel_i`=1, `bus_wr_i`=0) returns the flag in bit 7 and 0 in bits 6 to 0. A write changes no state. When no read is in progress, `bus_rdata_o` is 0.
- R7: `rst_n` low clears the flag at once, with no clock edge needed.
- R8: `irq_o` is always 0.
- R9: `rst_req_o` is 1 exactly when all three hold: the flag is 1, `rst_en_i` is 1, and the monitor is active.
- R10: The monitor is active unless `wait_i`=1 and `pwr_en_i`=0. While it is inactive:
  - the counter is held at zero;
  - the flag holds its value;
  - the reset request is 0.

  Once the monitor is active again, qualification takes a fresh 36 edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| below_fall_i | input | 1 | Raw comparator: supply under falling trip level |
| above_rise_i | input | 1 | Raw comparator: supply over rising trip level |
| wait_i | input | 1 | Device is in wait mode |
| pwr_en_i | input | 1 | Configuration: monitor stays on in wait mode |
| rst_en_i | input | 1 | Configuration: qualified low voltage requests reset |
| bus_sel_i | input | 1 | Bus access to the status byte |
| bus_wr_i | input | 1 | Access is a write (ignored) |
| bus_wdata_i | input | 8 | Write data (ignored) |
| bus_rdata_o | output | 8 | Status byte, flag in bit 7 |
| rst_req_o | output | 1 | Reset request |
| irq_o | output | 1 | Interrupt request, constantly 0 |

## Verification
The assertions assume that the two comparator results are never high at the same time, because the falling trip level sits below the rising one. The stimulus table therefore drives only three input states: low, band and high. The assertions also treat the wait and configuration bits as quasi-static levels. The bench changes those bits only between table steps, and each step lasts long enough for the synchronizers to settle. That makes the flag's edge counts exact rather than approximate.

// File: rtl/lvd_pkg.sv
package lvd_pkg;
  localparam int unsigned LVD_QUAL_CNT    = 36;
  localparam int unsigned LVD_SYNC_STAGES = 2;
  localparam int unsigned LVD_BYTE_W      = 8;
  localparam int unsigned LVD_FLAG_BIT    = 7;

  typedef enum logic [1:0] {
    SUP_BAND = 2'b00,
    SUP_LOW  = 2'b01,
    SUP_HIGH = 2'b10
  } sup_lvl_e;
endpackage

// File: rtl/lvd_rst_sync.sv
module lvd_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= 2'b00;
    else        sh_q <= {sh_q[0], 1'b1};
  end

  assign rst_sync_n = sh_q[1];
endmodule

// File: rtl/lvd_sync.sv
module lvd_sync #(
  parameter int unsigned WIDTH  = 2,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stg_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    logic [WIDTH-1:0] stg_d;
    if (s == 0) begin : g_first
      assign stg_d = d_i;
    end else begin : g_next
      assign stg_d = stg_q[s-1];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg_q[s] <= '0;
      else        stg_q[s] <= stg_d;
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/lvd_qual.sv
module lvd_qual
  import lvd_pkg::*;
#(
  parameter int unsigned QUAL_CNT = LVD_QUAL_CNT
) (
  input  logic     clk,
  input  logic     rst_n,
  input  sup_lvl_e lvl_i,
  input  logic     active_i,
  output logic     flag_o
);
  localparam int unsigned CW = $clog2(QUAL_CNT + 1);
  localparam logic [CW-1:0] LAST = CW'(QUAL_CNT - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          flag_q, flag_d;
  logic          cnt_en, flag_en;

  always_comb begin
    cnt_d   = '0;
    flag_d  = flag_q;
    cnt_en  = 1'b1;
    flag_en = 1'b0;
    if (active_i) begin
      unique case (lvl_i)
        SUP_HIGH: begin
          flag_d  = 1'b0;
          flag_en = 1'b1;
        end
        SUP_LOW: begin
          if (cnt_q == LAST) begin
            cnt_d   = cnt_q;
            flag_d  = 1'b1;
            flag_en = 1'b1;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      flag_q <= 1'b0;
    end else begin
      if (cnt_en)  cnt_q  <= cnt_d;
      if (flag_en) flag_q <= flag_d;
    end
  end

  assign flag_o = flag_q;

  // Independent run-length observer used only by the checks below.
  logic [5:0] run_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                              run_q <= '0;
    else if (active_i && lvl_i == SUP_LOW)   run_q <= (run_q == 6'd63) ? run_q : run_q + 1'b1;
    else                                     run_q <= '0;
  end

  a_r1_window: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_q) |-> (run_q >= 6'd32 && run_q <= 6'd40));
  a_r3_long_low: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q > 6'd40) |-> flag_q);
  a_r4_clear_high: assert property (@(posedge clk) disable iff (!rst_n)
    (active_i && lvl_i == SUP_HIGH) |=> !flag_q);
  a_r5_band_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (active_i && lvl_i == SUP_BAND) |=> $stable(flag_q));
  a_r10_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !active_i |=> ($stable(flag_q) && cnt_q == '0));
endmodule

// File: rtl/lvd_status_filter.sv
module lvd_status_filter
  import lvd_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       below_fall_i,
  input  logic       above_rise_i,
  input  logic       wait_i,
  input  logic       pwr_en_i,
  input  logic       rst_en_i,
  input  logic       bus_sel_i,
  input  logic       bus_wr_i,
  input  logic [7:0] bus_wdata_i,
  output logic [7:0] bus_rdata_o,
  output logic       rst_req_o,
  output logic       irq_o
);
  logic       rst_sync_n;
  logic [1:0] cmp_s;
  sup_lvl_e   lvl;
  logic       active;
  logic       flag;
  logic       rd_en;
  logic [7:0] wdata_unused;

  lvd_rst_sync i_rst (.clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n));

  lvd_sync #(.WIDTH(2), .STAGES(LVD_SYNC_STAGES)) i_sync (
    .clk  (clk),
    .rst_n(rst_sync_n),
    .d_i  ({above_rise_i, below_fall_i}),
    .q_o  (cmp_s)
  );

  always_comb begin
    if (cmp_s[1])      lvl = SUP_HIGH;
    else if (cmp_s[0]) lvl = SUP_LOW;
    else               lvl = SUP_BAND;
  end

  assign active = !(wait_i && !pwr_en_i);

  lvd_qual #(.QUAL_CNT(LVD_QUAL_CNT)) i_qual (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .lvl_i   (lvl),
    .active_i(active),
    .flag_o  (flag)
  );

  assign rd_en        = bus_sel_i && !bus_wr_i;
  assign wdata_unused = bus_wdata_i;

  always_comb begin
    bus_rdata_o = '0;
    if (rd_en) bus_rdata_o[LVD_FLAG_BIT] = flag;
  end

  assign rst_req_o = flag && rst_en_i && active;
  assign irq_o     = 1'b0;

  a_r6_reserved_zero: assert property (@(posedge clk) disable iff (!rst_sync_n)
    bus_rdata_o[6:0] == 7'd0);
  a_r9_req_gate: assert property (@(posedge clk) disable iff (!rst_sync_n)
    rst_req_o |-> (rst_en_i && !(wait_i && !pwr_en_i)));
  a_r8_no_irq: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !irq_o);
endmodule

// File: tb/test_lvd_status_filter.sv
module test_lvd_status_filter;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       below_fall_i, above_rise_i, wait_i, pwr_en_i, rst_en_i;
  logic       bus_sel_i, bus_wr_i;
  logic [7:0] bus_wdata_i;
  logic [7:0] bus_rdata_o;
  logic       rst_req_o, irq_o;

  int n_chk = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  lvd_status_filter i_lvd_status_filter (
    .clk(clk), .rst_n(rst_n), .below_fall_i(below_fall_i), .above_rise_i(above_rise_i),
    .wait_i(wait_i), .pwr_en_i(pwr_en_i), .rst_en_i(rst_en_i),
    .bus_sel_i(bus_sel_i), .bus_wr_i(bus_wr_i), .bus_wdata_i(bus_wdata_i),
    .bus_rdata_o(bus_rdata_o), .rst_req_o(rst_req_o), .irq_o(irq_o)
  );

  typedef struct packed {
    logic       lo;
    logic       hi;
    logic       wt;
    logic       pw;
    logic       re;
    logic [7:0] cyc;
    logic       flag;
    logic       req;
  } vec_t;

  localparam int NV = 18;
  localparam vec_t VEC [NV] = '{
    '{1'b1,1'b0,1'b0,1'b1,1'b0,8'd30,1'b0,1'b0}, // R2 short low
    '{1'b0,1'b0,1'b0,1'b1,1'b0,8'd5 ,1'b0,1'b0}, // R2 band restarts count
    '{1'b1,1'b0,1'b0,1'b1,1'b0,8'd37,1'b0,1'b0}, // R1 one edge early
    '{1'b1,1'b0,1'b0,1'b1,1'b0,8'd1 ,1'b1,1'b0}, // R1 set at edge 38
    '{1'b1,1'b0,1'b0,1'b1,1'b0,8'd10,1'b1,1'b0}, // R3 stays set
    '{1'b0,1'b0,1'b0,1'b1,1'b0,8'd20,1'b1,1'b0}, // R5 band holds 1
    '{1'b0,1'b1,1'b0,1'b1,1'b0,8'd2 ,1'b1,1'b0}, // R4 not yet cleared
    '{1'b0,1'b1,1'b0,1'b1,1'b0,8'd1 ,1'b0,1'b0}, // R4 cleared at edge 3
    '{1'b0,1'b0,1'b0,1'b1,1'b0,8'd10,1'b0,1'b0}, // R5 band holds 0
    '{1'b1,1'b0,1'b0,1'b1,1'b0,8'd40,1'b1,1'b0}, // R1 set again
    '{1'b1,1'b0,1'b0,1'b1,1'b1,8'd1 ,1'b1,1'b1}, // R9 reset request
    '{1'b1,1'b0,1'b1,1'b1,1'b1,8'd3 ,1'b1,1'b1}, // R9 wait, powered
    '{1'b0,1'b1,1'b1,1'b1,1'b1,8'd3 ,1'b0,1'b0}, // R4 clear in wait
    '{1'b1,1'b0,1'b1,1'b0,1'b1,8'd50,1'b0,1'b0}, // R10 unpowered, no set
    '{1'b1,1'b0,1'b1,1'b1,1'b1,8'd35,1'b0,1'b0}, // R10 fresh count
    '{1'b1,1'b0,1'b1,1'b1,1'b1,8'd1 ,1'b1,1'b1}, // R10 set at edge 36
    '{1'b0,1'b1,1'b1,1'b0,1'b1,8'd10,1'b1,1'b0}, // R10 held, req low
    '{1'b0,1'b1,1'b0,1'b0,1'b1,8'd3 ,1'b0,1'b0}  // R4 active again
  };

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    rst_n = 1'b0; below_fall_i = 1'b0; above_rise_i = 1'b0;
    wait_i = 1'b0; pwr_en_i = 1'b1; rst_en_i = 1'b0;
    bus_sel_i = 1'b1; bus_wr_i = 1'b0; bus_wdata_i = 8'h00;
    do_reset();
    check("R7 reset byte", bus_rdata_o, 8'h00);
    check("R9 reset req", {7'd0, rst_req_o}, 8'h00);
    check("R8 reset irq", {7'd0, irq_o}, 8'h00);

    for (int i = 0; i < NV; i++) begin
      below_fall_i = VEC[i].lo; above_rise_i = VEC[i].hi;
      wait_i = VEC[i].wt; pwr_en_i = VEC[i].pw; rst_en_i = VEC[i].re;
      repeat (int'(VEC[i].cyc)) @(posedge clk);
      @(negedge clk);
      check($sformatf("R1-5/R10 vec%0d byte", i), bus_rdata_o, {VEC[i].flag, 7'd0});
      check($sformatf("R9 vec%0d req", i), {7'd0, rst_req_o}, {7'd0, VEC[i].req});
      check($sformatf("R8 vec%0d irq", i), {7'd0, irq_o}, 8'h00);
    end

    // R6: set the flag, then writes must not disturb it
    wait_i = 1'b0; pwr_en_i = 1'b1; rst_en_i = 1'b0;
    above_rise_i = 1'b0; below_fall_i = 1'b1;
    repeat (40) @(posedge clk);
    @(negedge clk);
    check("R6 read flag", bus_rdata_o, 8'h80);
    below_fall_i = 1'b0;
    bus_wr_i = 1'b1; bus_wdata_i = 8'h00;
    @(posedge clk); @(negedge clk);
    check("R6 no data during write", bus_rdata_o, 8'h00);
    bus_wdata_i = 8'hFF;
    @(posedge clk); @(negedge clk);
    bus_wr_i = 1'b0; bus_sel_i = 1'b0;
    @(negedge clk);
    check("R6 idle bus", bus_rdata_o, 8'h00);
    bus_sel_i = 1'b1;
    @(negedge clk);
    check("R6 write ignored", bus_rdata_o, 8'h80);

    // R7: asynchronous reset clears a set flag before any edge
    @(posedge clk); #2;
    rst_n = 1'b0;
    #1;
    check("R7 async clear", bus_rdata_o, 8'h00);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R7 after release", bus_rdata_o, 8'h00);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule